// File: doc/BRIEF.md
# Folded Two-Round SHA-256 Stage

This block is one stage of a partially unrolled SHA-256 compression pipeline. A stage at position s works out compression rounds 2s and 2s+1 with a single set of round logic. It does this by feeding its own registered results back into that logic on the clock after it takes new work. A chain of 32 of these stages therefore covers all 64 rounds. Seen from outside, such a chain takes a new block every second clock and never needs bursts.

Each stage takes the eight-word working state, a sixteen-word sliding window of message-schedule words and a valid strobe. It hands the updated state and window, with its own valid pulse, to the next stage once both of its rounds are done. Each stage holds the two round constants it needs. A 2:1 mux driven by the feedback phase picks between them. The sum of h, the message word and the constant, which is part of T1, is prepared one round ahead and kept in a register. On the first pass that sum comes straight from the incoming ports and does not go through the feedback mux. Message padding and the final addition of the chaining value are left to the surrounding logic.

Top module: `sha_fold_stage`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is low and the stage is idle, so it accepts the next `in_valid`.
- R2: Each round computes T1 = h + W + K + Σ1(e) + Ch(e,f,g) and T2 = Σ0(a) + Maj(a,b,c). The new a is T1+T2 and the new e is d+T1. The new b,c,d are the old a,b,c and the new f,g,h are the old e,f,g. State word j (a=0 … h=7) sits in bits [32j+31:32j].
- R3: Per round the window moves down one word. The new top word (word 15) is w0 + σ0(w1) + w9 + σ1(w14), where σ0 = ror7^ror18^shr3 and σ1 = ror17^ror19^shr10. Window word j sits in bits [32j+31:32j], and word 0 is the W used by the round.
- R4: The stage with parameter `STAGE_IDX`=s uses constant K[2s] in its first round and K[2s+1] in its second.
- R5: `in_valid` is taken only when the stage is idle. A strobe in the cycle right after a taken one is ignored and does not change the result.
- R6: `out_valid` is a one-cycle pulse, two clocks after a taken `in_valid`. It never stays high for two cycles in a row.
- R7: 32 chained stages with indices 0..31 give the full 64-round compression. Added to the initial hash value, this gives the standard digest (for "abc": ba7816bf…f20015ad).
- R8: A chain fed a block every second clock sends back results every second clock, in order, 64 clocks after each input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | New work present on the inputs |
| in_state | input | 256 | Working state a..h, a in the low word |
| in_win | input | 512 | Message-schedule window, word 0 in the low word |
| out_valid | output | 1 | One-cycle pulse: outputs hold the result of both rounds |
| out_state | output | 256 | State after the second round |
| out_win | output | 512 | Window after two shifts |

## Verification
The bench goes after a repeated strobe in the feedback cycle. A stage that takes it would start over on the new data and produce the wrong state, or pulse `out_valid` twice. It checks the exact two-clock latency and a single-cycle valid, because a phase flag that fails to toggle makes the output appear a cycle early or stick. The "abc" digest and random blocks run through a full 32-stage chain. These catch a swapped constant pair, a first pass that reads the stale partial sum, or a wrong schedule rotation, since any of these damages every digest. Streaming blocks every second clock also shows that feedback cycles and new work never collide.

// File: rtl/sha_fold_pkg.sv
// Shared widths, types and SHA-256 helper functions for the folded stage.
// Assumes 32-bit words; the constant table is computed by index, modulo 64.
package sha_fold_pkg;
    localparam int WORD_W      = 32;
    localparam int STATE_WORDS = 8;
    localparam int WIN_WORDS   = 16;
    localparam int STATE_W     = WORD_W * STATE_WORDS;
    localparam int WIN_W       = WORD_W * WIN_WORDS;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t ror(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return ror(x, 2) ^ ror(x, 13) ^ ror(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return ror(x, 6) ^ ror(x, 11) ^ ror(x, 25);
    endfunction

    function automatic word_t sml_sig0(input word_t x);
        return ror(x, 7) ^ ror(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_sig1(input word_t x);
        return ror(x, 17) ^ ror(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t choose(input word_t e, input word_t f, input word_t g);
        return (e & f) ^ (~e & g);
    endfunction

    function automatic word_t majority(input word_t a, input word_t b, input word_t c);
        return (a & b) ^ (a & c) ^ (b & c);
    endfunction

    function automatic word_t round_const(input int idx);
        logic [5:0] i;
        i = idx[5:0];
        case (i)
            6'd0:  return 32'h428a2f98;  6'd1:  return 32'h71374491;
            6'd2:  return 32'hb5c0fbcf;  6'd3:  return 32'he9b5dba5;
            6'd4:  return 32'h3956c25b;  6'd5:  return 32'h59f111f1;
            6'd6:  return 32'h923f82a4;  6'd7:  return 32'hab1c5ed5;
            6'd8:  return 32'hd807aa98;  6'd9:  return 32'h12835b01;
            6'd10: return 32'h243185be;  6'd11: return 32'h550c7dc3;
            6'd12: return 32'h72be5d74;  6'd13: return 32'h80deb1fe;
            6'd14: return 32'h9bdc06a7;  6'd15: return 32'hc19bf174;
            6'd16: return 32'he49b69c1;  6'd17: return 32'hefbe4786;
            6'd18: return 32'h0fc19dc6;  6'd19: return 32'h240ca1cc;
            6'd20: return 32'h2de92c6f;  6'd21: return 32'h4a7484aa;
            6'd22: return 32'h5cb0a9dc;  6'd23: return 32'h76f988da;
            6'd24: return 32'h983e5152;  6'd25: return 32'ha831c66d;
            6'd26: return 32'hb00327c8;  6'd27: return 32'hbf597fc7;
            6'd28: return 32'hc6e00bf3;  6'd29: return 32'hd5a79147;
            6'd30: return 32'h06ca6351;  6'd31: return 32'h14292967;
            6'd32: return 32'h27b70a85;  6'd33: return 32'h2e1b2138;
            6'd34: return 32'h4d2c6dfc;  6'd35: return 32'h53380d13;
            6'd36: return 32'h650a7354;  6'd37: return 32'h766a0abb;
            6'd38: return 32'h81c2c92e;  6'd39: return 32'h92722c85;
            6'd40: return 32'ha2bfe8a1;  6'd41: return 32'ha81a664b;
            6'd42: return 32'hc24b8b70;  6'd43: return 32'hc76c51a3;
            6'd44: return 32'hd192e819;  6'd45: return 32'hd6990624;
            6'd46: return 32'hf40e3585;  6'd47: return 32'h106aa070;
            6'd48: return 32'h19a4c116;  6'd49: return 32'h1e376c08;
            6'd50: return 32'h2748774c;  6'd51: return 32'h34b0bcb5;
            6'd52: return 32'h391c0cb3;  6'd53: return 32'h4ed8aa4a;
            6'd54: return 32'h5b9cca4f;  6'd55: return 32'h682e6ff3;
            6'd56: return 32'h748f82ee;  6'd57: return 32'h78a5636f;
            6'd58: return 32'h84c87814;  6'd59: return 32'h8cc70208;
            6'd60: return 32'h90befffa;  6'd61: return 32'ha4506ceb;
            6'd62: return 32'hbef9a3f7;  default: return 32'hc67178f2;
        endcase
    endfunction
endpackage

// File: rtl/sha_fold_ctrl.sv
// Phase and valid control for the two-round folded stage.
// Takes new work only when idle; the cycle after that is the feedback round.
// Assumes upstream spaces its strobes at least two clocks apart.
module sha_fold_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic take_o,
    output logic phase_o,
    output logic out_valid_o
);
    logic phase_q;
    logic vld_q;

    assign take_o      = in_valid & ~phase_q;
    assign phase_o     = phase_q;
    assign out_valid_o = vld_q;

    // Phase flag: set on a taken strobe, cleared after the feedback round.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            vld_q   <= 1'b0;
        end else begin
            phase_q <= take_o;
            vld_q   <= phase_q;
        end
    end

    // R6
    vld_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);

    // R6
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(in_valid, 2));

    // R5
    phase_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q |=> !phase_q);

    // R5
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> !phase_q);
endmodule

// File: rtl/sha_round_core.sv
// One SHA-256 compression round, combinational.
// Assumes the caller supplies the partial sum h + W + K already added.
module sha_round_core
    import sha_fold_pkg::*;
(
    input  logic [STATE_W-1:0] st_i,
    input  word_t              part_i,
    output logic [STATE_W-1:0] st_o
);
    word_t a, b, c, d, e, f, g;
    word_t t1, t2;

    // Unpack the working words and form the two temporaries.
    always_comb begin
        a  = st_i[0*WORD_W +: WORD_W];
        b  = st_i[1*WORD_W +: WORD_W];
        c  = st_i[2*WORD_W +: WORD_W];
        d  = st_i[3*WORD_W +: WORD_W];
        e  = st_i[4*WORD_W +: WORD_W];
        f  = st_i[5*WORD_W +: WORD_W];
        g  = st_i[6*WORD_W +: WORD_W];
        t1 = part_i + big_sig1(e) + choose(e, f, g);
        t2 = big_sig0(a) + majority(a, b, c);
    end

    assign st_o = {g, f, e, d + t1, c, b, a, t1 + t2};
endmodule

// File: rtl/sha_sched_step.sv
// One step of the message-schedule window: drop word 0, append a new word.
// Assumes word 0 of the window is the W consumed by the current round.
module sha_sched_step
    import sha_fold_pkg::*;
(
    input  logic [WIN_W-1:0] win_i,
    output logic [WIN_W-1:0] win_o
);
    word_t fresh;

    // New top word from four taps of the current window.
    always_comb begin
        fresh = win_i[0*WORD_W +: WORD_W]
              + sml_sig0(win_i[1*WORD_W +: WORD_W])
              + win_i[9*WORD_W +: WORD_W]
              + sml_sig1(win_i[14*WORD_W +: WORD_W]);
    end

    for (genvar j = 0; j < WIN_WORDS - 1; j++) begin : g_shift
        assign win_o[j*WORD_W +: WORD_W] = win_i[(j+1)*WORD_W +: WORD_W];
    end
    assign win_o[(WIN_WORDS-1)*WORD_W +: WORD_W] = fresh;
endmodule

// File: rtl/sha_fold_stage.sv
// Folded SHA-256 stage: rounds 2*STAGE_IDX and 2*STAGE_IDX+1 on one round core.
// The first round reads the ports; the second reads the stage's own registers.
// The partial T1 sum for the second round is registered one round early.
// Data registers carry no reset; only control state does.
module sha_fold_stage
    import sha_fold_pkg::*;
#(
    parameter int STAGE_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [STATE_W-1:0] in_state,
    input  logic [WIN_W-1:0]   in_win,
    output logic               out_valid,
    output logic [STATE_W-1:0] out_state,
    output logic [WIN_W-1:0]   out_win
);
    localparam int    RND_FIRST  = 2 * STAGE_IDX;
    localparam int    RND_SECOND = RND_FIRST + 1;
    localparam word_t K_FIRST    = round_const(RND_FIRST);
    localparam word_t K_SECOND   = round_const(RND_SECOND);
    localparam int    H_LSB      = 7 * WORD_W;
    localparam int    G_LSB      = 6 * WORD_W;

    logic               take, phase;
    logic [STATE_W-1:0] st_q, src_st, st_nxt;
    logic [WIN_W-1:0]   win_q, src_win, win_nxt;
    word_t              part_q, part_cur, part_nxt, k_ahead;

    sha_fold_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .take_o      (take),
        .phase_o     (phase),
        .out_valid_o (out_valid)
    );

    // Feedback select and constant mux for the look-ahead partial sum.
    always_comb begin
        src_st   = phase ? st_q  : in_state;
        src_win  = phase ? win_q : in_win;
        k_ahead  = phase ? K_FIRST : K_SECOND;
        // first pass: straight from the incoming word, no feedback mux
        part_cur = phase ? part_q
                         : in_state[H_LSB +: WORD_W] + in_win[0 +: WORD_W] + K_FIRST;
        // next round's h is this round's g; next W is this window's word 1
        part_nxt = src_st[G_LSB +: WORD_W] + src_win[WORD_W +: WORD_W] + k_ahead;
    end

    sha_round_core u_round (
        .st_i   (src_st),
        .part_i (part_cur),
        .st_o   (st_nxt)
    );

    sha_sched_step u_sched (
        .win_i (src_win),
        .win_o (win_nxt)
    );

    // Data registers: load on a taken strobe and on the feedback round.
    always_ff @(posedge clk) begin
        if (take || phase) begin
            st_q   <= st_nxt;
            win_q  <= win_nxt;
            part_q <= part_nxt;
        end
    end

    assign out_state = st_q;
    assign out_win   = win_q;

    // R3
    win_slide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_win[0 +: 14*WORD_W] == $past(in_win[2*WORD_W +: 14*WORD_W], 2));
endmodule

// File: tb/sha_fold_stage_tb.sv
module sha_fold_stage_tb;
    import sha_fold_pkg::*;

    localparam int NSTG = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [255:0] in_state = '0;
    logic [511:0] in_win = '0;

    logic         c_v   [NSTG+1];
    logic [255:0] c_st  [NSTG+1];
    logic [511:0] c_win [NSTG+1];

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sha_fold_stage #(.STAGE_IDX(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_state(in_state), .in_win(in_win),
        .out_valid(c_v[1]), .out_state(c_st[1]), .out_win(c_win[1])
    );

    for (genvar k = 1; k < NSTG; k++) begin : g_chain
        sha_fold_stage #(.STAGE_IDX(k)) u_stg (
            .clk(clk), .rst_n(rst_n), .in_valid(c_v[k]),
            .in_state(c_st[k]), .in_win(c_win[k]),
            .out_valid(c_v[k+1]), .out_state(c_st[k+1]), .out_win(c_win[k+1])
        );
    end

    // independent reference arithmetic
    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [255:0] ref_round(input logic [255:0] s,
                                               input logic [31:0] w, input logic [31:0] k);
        logic [31:0] a, b, c, d, e, f, g, h, x1, x2;
        {h, g, f, e, d, c, b, a} = s;
        x1 = h + (rr(e,6) ^ rr(e,11) ^ rr(e,25)) + ((e & f) ^ (~e & g)) + k + w;
        x2 = (rr(a,2) ^ rr(a,13) ^ rr(a,22)) + ((a & b) ^ (a & c) ^ (b & c));
        return {g, f, e, d + x1, c, b, a, x1 + x2};
    endfunction

    function automatic logic [511:0] ref_sched(input logic [511:0] w);
        logic [31:0] n, w1, w14;
        w1  = w[63:32];
        w14 = w[479:448];
        n = w[31:0] + (rr(w1,7) ^ rr(w1,18) ^ (w1 >> 3)) + w[319:288]
          + (rr(w14,17) ^ rr(w14,19) ^ (w14 >> 10));
        return {n, w[511:32]};
    endfunction

    function automatic logic [255:0] ref_iv();
        return {32'h5be0cd19, 32'h1f83d9ab, 32'h9b05688c, 32'h510e527f,
                32'ha54ff53a, 32'h3c6ef372, 32'hbb67ae85, 32'h6a09e667};
    endfunction

    function automatic logic [255:0] ref_digest(input logic [511:0] blk);
        logic [255:0] s, iv, d;
        logic [511:0] w;
        iv = ref_iv();
        s = iv;
        w = blk;
        for (int r = 0; r < 64; r++) begin
            s = ref_round(s, w[31:0], round_const(r));
            w = ref_sched(w);
        end
        for (int j = 0; j < 8; j++) d[32*j +: 32] = s[32*j +: 32] + iv[32*j +: 32];
        return d;
    endfunction

    function automatic logic [255:0] fin_add(input logic [255:0] s);
        logic [255:0] iv, d;
        iv = ref_iv();
        for (int j = 0; j < 8; j++) d[32*j +: 32] = s[32*j +: 32] + iv[32*j +: 32];
        return d;
    endfunction

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int j = 0; j < 16; j++) v[32*j +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // one stage, two rounds: drive at a falling edge, result after two rising edges
    task automatic one_pair(input string req, input logic [255:0] s, input logic [511:0] w,
                            input bit extra_strobe);
        logic [255:0] es;
        logic [511:0] ew;
        es = ref_round(ref_round(s, w[31:0], round_const(0)), w[63:32], round_const(1));
        ew = ref_sched(ref_sched(w));
        @(negedge clk);
        in_valid = 1'b1; in_state = s; in_win = w;
        @(negedge clk);
        chk({req, " mid-pair valid low"}, {511'b0, c_v[1]}, 512'd0);
        if (extra_strobe) begin
            in_state = ~s; in_win = ~w;   // R5: must be ignored
        end else in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, {511'b0, c_v[1]}, 512'd1);
        chk({req, " state"}, {256'b0, c_st[1]}, {256'b0, es});
        chk({req, " window"}, c_win[1], ew);
        @(negedge clk);
        chk({req, " valid pulse ends (R6)"}, {511'b0, c_v[1]}, 512'd0);
    endtask

    task automatic drain();
        repeat (80) @(negedge clk);
    endtask

    initial begin
        #1200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [511:0] abc_blk, blk [4];
        logic [255:0] st_out [4];
        int got, lat, last_t, t;
        void'($urandom(32'd20240607));

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid low in reset", {511'b0, c_v[1]}, 512'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid low after reset", {511'b0, c_v[1]}, 512'd0);

        // R2 R3 R4: directed and random pairs on stage 0
        one_pair("R2 zero state", '0, '0, 1'b0);
        one_pair("R2 all ones", '1, '1, 1'b0);
        for (int i = 0; i < 6; i++) one_pair("R3 R4 random pair", rnd512()[255:0], rnd512(), 1'b0);
        // R5: strobe in feedback cycle is ignored
        one_pair("R5 extra strobe", rnd512()[255:0], rnd512(), 1'b1);
        drain();

        // R7: "abc" digest through the 32-stage chain
        abc_blk = '0;
        abc_blk[31:0] = 32'h61626380;
        abc_blk[511:480] = 32'h00000018;
        @(negedge clk);
        in_valid = 1'b1; in_state = ref_iv(); in_win = abc_blk;
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!c_v[NSTG] && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R8 chain latency", 512'(lat), 512'd64);
        chk("R7 abc digest", {256'b0, fin_add(c_st[NSTG])},
            {256'b0, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad} >> 0 == 0 ? 512'd0 :
            {256'b0, 32'hf20015ad, 32'hb410ff61, 32'h96177a9c, 32'hb00361a3,
                     32'h5dae2223, 32'h414140de, 32'h8f01cfea, 32'hba7816bf});
        chk("R7 abc vs model", {256'b0, fin_add(c_st[NSTG])}, {256'b0, ref_digest(abc_blk)});
        drain();

        // R8: stream four random blocks, one every second clock
        for (int i = 0; i < 4; i++) blk[i] = rnd512();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_state = ref_iv(); in_win = blk[i];
            @(negedge clk);
            in_valid = 1'b0;
        end
        got = 0; t = 0; last_t = -2;
        while (got < 4 && t < 300) begin
            @(negedge clk);
            t++;
            if (c_v[NSTG]) begin
                st_out[got] = c_st[NSTG];
                if (got > 0) chk("R8 output spacing", 512'(t - last_t), 512'd2);
                last_t = t;
                got++;
            end
        end
        chk("R8 output count", 512'(got), 512'd4);
        for (int i = 0; i < 4; i++)
            chk("R7 R8 streamed digest", {256'b0, fin_add(st_out[i])}, {256'b0, ref_digest(blk[i])});
        summary();
    end
endmodule